// File: doc/BRIEF.md
# Locked-Access Memory Arbiter

This block arbitrates between several processor agents that share one memory port. Ordinary requests are served round-robin, one grant per cycle. An agent can also run an indivisible read-modify-write sequence by holding its lock input. For that sequence the arbiter picks one of two protection scopes.

The first scope is a line lock. It is cheap: it only stalls other agents that target the same cache line, and every other line keeps flowing. The second scope is a bus lock. It is expensive: no other agent is served until the sequence ends. The line lock is chosen only when three things hold: the target line is held exclusive or modified, the access lies entirely inside one line, and the line-lock capability is enabled.

The chosen scope is reported every cycle on a mode output. Cache storage and coherence traffic are outside the block; the line state comes in as a per-agent flag.

Top module: `lock_arbiter`

## Requirements
- R1: In every cycle `gnt_o` has at most one bit set, and only for an agent whose `req_i` bit is set. Eligible requests are served in round-robin order, starting the search at the agent after the one granted last.
- R2: `lock_mode_o` is a registered code: 0 means no lock, 1 means line lock, 2 means bus lock. It changes in the cycle after the lock owner's locked request is granted.
- R3: A granted locked request takes the line lock (code 1) when three conditions all hold: `cache_lock_en_i` is 1, its `excl_i` bit is 1, and the low 6 address bits plus its size in bytes are at most 64. Exactly 64 still counts as fitting.
- R4: A granted locked request takes the bus lock (code 2) when its offset plus size exceeds 64 (it spans two lines), or when its `excl_i` bit is 0 (the data is not cached).
- R5: With `cache_lock_en_i` at 0, every granted locked request takes the bus lock, even when the line is exclusive and the access fits.
- R6: While the mode is bus lock, only the lock owner can be granted.
- R7: While the mode is line lock, a non-owner is not granted if its address bits [31:6] equal the locked line, or if it raises its own lock input. Non-owners with unlocked requests to other lines are still granted round-robin.
- R8: When the owner drops its `lock_i` bit, the mode returns to 0 in the next cycle.
- R9: After reset the mode is 0 and the round-robin search starts at agent 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cache_lock_en_i | input | 1 | Enables the line-lock scope |
| req_i | input | N_AGENTS | Access request per agent |
| lock_i | input | N_AGENTS | Locked sequence held per agent |
| excl_i | input | N_AGENTS | Target line held exclusive or modified |
| addr_i | input | N_AGENTS*ADDR_W | Byte address per agent |
| size_i | input | N_AGENTS*SIZE_W | Access size in bytes per agent |
| gnt_o | output | N_AGENTS | One-hot grant |
| lock_mode_o | output | 2 | 0 none, 1 line, 2 bus |

## Verification
The assertions assume that an agent keeps its lock input, address and size steady from the cycle its locked request is granted until it drops the lock. They also assume that the lock owner raises no second locked sequence without first releasing. The stimulus holds every agent's fields constant across each scenario and changes them only after the release has been observed. The bench also lowers every lock input between scenarios, so each locked sequence starts from mode 0.

// File: rtl/lock_arb_pkg.sv
package lock_arb_pkg;
  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_LINE = 2'd1,
    LK_BUS  = 2'd2
  } lk_mode_e;
endpackage

// File: rtl/lock_scope_sel.sv
module lock_scope_sel #(
  parameter int LINE_BYTES = 64,
  parameter int SIZE_W     = $clog2(LINE_BYTES) + 1
) (
  input  logic [$clog2(LINE_BYTES)-1:0] offset_i,
  input  logic [SIZE_W-1:0]             size_i,
  input  logic                          excl_i,
  input  logic                          en_i,
  output logic                          use_line_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SUM_W = (OFF_W > SIZE_W ? OFF_W : SIZE_W) + 1;

  logic [SUM_W-1:0] end_byte;
  logic             fits;

  assign end_byte   = SUM_W'(offset_i) + SUM_W'(size_i);
  assign fits       = end_byte <= SUM_W'(LINE_BYTES);
  assign use_line_o = en_i & excl_i & fits;
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     elig_i,
  input  logic [IDX_W-1:0] start_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    vld_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      int unsigned cand;
      cand = int'(start_i) + k;
      if (cand >= N) cand = cand - N;
      if (!vld_o && elig_i[cand]) begin
        vld_o       = 1'b1;
        idx_o       = IDX_W'(cand);
        gnt_o[cand] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter
  import lock_arb_pkg::*;
#(
  parameter int N_AGENTS   = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SIZE_W     = $clog2(LINE_BYTES) + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cache_lock_en_i,
  input  logic [N_AGENTS-1:0]          req_i,
  input  logic [N_AGENTS-1:0]          lock_i,
  input  logic [N_AGENTS-1:0]          excl_i,
  input  logic [N_AGENTS*ADDR_W-1:0]   addr_i,
  input  logic [N_AGENTS*SIZE_W-1:0]   size_i,
  output logic [N_AGENTS-1:0]          gnt_o,
  output logic [1:0]                   lock_mode_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

  lk_mode_e           mode_q, mode_d;
  logic [IDX_W-1:0]   owner_q, owner_d, ptr_q;
  logic [LINE_W-1:0]  line_q, line_d;
  logic [N_AGENTS-1:0] elig;
  logic [IDX_W-1:0]   gnt_idx;
  logic               gnt_vld;
  logic [ADDR_W-1:0]  sel_addr;
  logic [SIZE_W-1:0]  sel_size;
  logic               use_line;

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_elig
    logic same_line;
    logic is_owner;
    assign same_line = addr_i[i*ADDR_W+OFF_W +: LINE_W] == line_q;
    assign is_owner  = IDX_W'(i) == owner_q;
    // bus: owner only; line: owner or unlocked traffic to other lines
    assign elig[i] = req_i[i] & ((mode_q == LK_NONE) | is_owner |
                     ((mode_q == LK_LINE) & ~lock_i[i] & ~same_line));
  end

  rr_pick #(.N(N_AGENTS), .IDX_W(IDX_W)) u_pick (
    .elig_i  (elig),
    .start_i (ptr_q),
    .gnt_o   (gnt_o),
    .idx_o   (gnt_idx),
    .vld_o   (gnt_vld)
  );

  assign sel_addr = addr_i[int'(gnt_idx)*ADDR_W +: ADDR_W];
  assign sel_size = size_i[int'(gnt_idx)*SIZE_W +: SIZE_W];

  lock_scope_sel #(.LINE_BYTES(LINE_BYTES), .SIZE_W(SIZE_W)) u_scope (
    .offset_i   (sel_addr[OFF_W-1:0]),
    .size_i     (sel_size),
    .excl_i     (excl_i[gnt_idx]),
    .en_i       (cache_lock_en_i),
    .use_line_o (use_line)
  );

  always_comb begin
    mode_d  = mode_q;
    owner_d = owner_q;
    line_d  = line_q;
    if (mode_q != LK_NONE) begin
      if (!lock_i[owner_q]) mode_d = LK_NONE;
    end else if (gnt_vld && lock_i[gnt_idx]) begin
      mode_d  = use_line ? LK_LINE : LK_BUS;
      owner_d = gnt_idx;
      line_d  = sel_addr[ADDR_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= LK_NONE;
      owner_q <= '0;
      line_q  <= '0;
      ptr_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      owner_q <= owner_d;
      line_q  <= line_d;
      if (gnt_vld) ptr_q <= (int'(gnt_idx) == N_AGENTS - 1) ? '0 : gnt_idx + 1'b1;
    end
  end

  assign lock_mode_o = mode_q;
endmodule

// File: rtl/lock_arbiter_chk.sv
module lock_arbiter_chk #(
  parameter int N_AGENTS   = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int IDX_W      = 2,
  parameter int LINE_W     = 26
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cache_lock_en_i,
  input logic [N_AGENTS-1:0]        req_i,
  input logic [N_AGENTS-1:0]        lock_i,
  input logic [N_AGENTS*ADDR_W-1:0] addr_i,
  input logic [N_AGENTS-1:0]        gnt_o,
  input logic [1:0]                 lock_mode_o,
  input logic [IDX_W-1:0]           owner_q,
  input logic [LINE_W-1:0]          line_q
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [N_AGENTS-1:0] held_off;
  logic [N_AGENTS-1:0] owner_bit;
  for (genvar i = 0; i < N_AGENTS; i++) begin : g_h
    assign owner_bit[i] = IDX_W'(i) == owner_q;
    assign held_off[i]  = !owner_bit[i] &&
                          (lock_i[i] || addr_i[i*ADDR_W+OFF_W +: LINE_W] == line_q);
  end

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gnt_o));
  a_r1_only_req: assert property (@(posedge clk_i) disable iff (!rst_ni) (gnt_o & ~req_i) == '0);
  a_r6_bus_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_mode_o == 2'd2 |-> (gnt_o & ~owner_bit) == '0);
  a_r7_line_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_mode_o == 2'd1 |-> (gnt_o & held_off) == '0);
  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_mode_o != 2'd0 && !lock_i[owner_q]) |=> lock_mode_o == 2'd0);
  a_r5_no_line_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_mode_o == 2'd0 && !cache_lock_en_i && (gnt_o & lock_i) != '0) |=> lock_mode_o == 2'd2);
  a_r2_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni) lock_mode_o != 2'd3);
endmodule

bind lock_arbiter lock_arbiter_chk #(
  .N_AGENTS(N_AGENTS), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
  .IDX_W(IDX_W), .LINE_W(LINE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cache_lock_en_i(cache_lock_en_i),
  .req_i(req_i), .lock_i(lock_i), .addr_i(addr_i), .gnt_o(gnt_o),
  .lock_mode_o(lock_mode_o), .owner_q(owner_q), .line_q(line_q)
);

// File: tb/tb_lock_arbiter.sv
module tb_lock_arbiter;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [N-1:0] req = '0, lck = '0, exc = '0;
  logic [31:0] addr [N];
  logic [6:0]  size [N];
  logic [N*32-1:0] addr_p;
  logic [N*7-1:0]  size_p;
  logic [N-1:0] gnt;
  logic [1:0]   mode;

  int checks = 0, fails = 0, cyc = 0;
  int m_mode = 0, m_owner = 0, m_ptr = 0;
  logic [25:0] m_line = '0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) begin
      addr_p[i*32 +: 32] = addr[i];
      size_p[i*7 +: 7]   = size[i];
    end

  lock_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .cache_lock_en_i(en), .req_i(req), .lock_i(lck),
    .excl_i(exc), .addr_i(addr_p), .size_i(size_p), .gnt_o(gnt), .lock_mode_o(mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int pick();
    for (int k = 0; k < N; k++) begin
      int a = (m_ptr + k) % N;
      bit ok;
      ok = req[a] && (m_mode == 0 || a == m_owner ||
           (m_mode == 1 && !lck[a] && addr[a][31:6] != m_line));
      if (ok) return a;
    end
    return -1;
  endfunction

  task automatic cycle();
    int g;
    string t;
    #1;
    g = pick();
    t = (m_mode == 2) ? "R6" : (m_mode == 1) ? "R7" : "R1";
    chk(t, int'(gnt), g < 0 ? 0 : (1 << g));
    chk("R2", int'(mode), m_mode);
    @(posedge clk);
    cyc++;
    if (m_mode != 0) begin
      if (!lck[m_owner]) m_mode = 0;
    end else if (g >= 0 && lck[g]) begin
      int e;
      e = int'(addr[g][5:0]) + int'(size[g]);
      m_mode  = (en && exc[g] && e <= 64) ? 1 : 2;
      m_owner = g;
      m_line  = addr[g][31:6];
    end
    if (g >= 0) m_ptr = (g + 1) % N;
    @(negedge clk);
  endtask

  task automatic set_ag(input int i, input bit r, input bit l, input bit x,
                        input logic [31:0] a, input logic [6:0] s);
    req[i] = r; lck[i] = l; exc[i] = x; addr[i] = a; size[i] = s;
  endtask

  task automatic clear();
    for (int i = 0; i < N; i++) set_ag(i, 0, 0, 0, 32'h0, 7'd4);
  endtask

  // run until the model takes a lock, then verify the chosen scope
  task automatic take_lock(input string tag, input int exp_mode);
    for (int k = 0; k < 8 && m_mode == 0; k++) cycle();
    chk(tag, int'(mode), exp_mode);
  endtask

  task automatic release_lock(input int who);
    lck[who] = 0; req[who] = 0;
    cycle();
    cycle();
    chk("R8", int'(mode), 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin addr[i] = '0; size[i] = 7'd4; end
    #1;
    chk("R9", int'(mode), 0);
    chk("R9", int'(gnt), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R9: all requesting at once, agent 0 goes first
    for (int i = 0; i < N; i++) set_ag(i, 1, 0, 0, 32'h100 * i, 7'd4);
    #1; chk("R9", int'(gnt), 1);
    for (int k = 0; k < 9; k++) cycle();
    req = 4'b1010; for (int k = 0; k < 5; k++) cycle();
    req = 4'b0100; for (int k = 0; k < 3; k++) cycle();

    // R3 line lock, R7 same line stalled, other line flows
    clear();
    set_ag(1, 1, 1, 1, 32'h0000_1010, 7'd8);
    set_ag(2, 1, 0, 0, 32'h0000_1030, 7'd4);
    set_ag(3, 1, 0, 0, 32'h0000_2000, 7'd4);
    set_ag(0, 1, 1, 1, 32'h0000_3000, 7'd4);
    take_lock("R3", 1);
    for (int k = 0; k < 6; k++) cycle();
    lck[0] = 0; for (int k = 0; k < 3; k++) cycle();
    release_lock(1);
    clear(); cycle();

    // R4 span two lines: 60 + 8 > 64
    set_ag(2, 1, 1, 1, 32'h0000_403C, 7'd8);
    set_ag(0, 1, 0, 0, 32'h0000_9000, 7'd4);
    set_ag(3, 1, 0, 0, 32'h0000_A000, 7'd4);
    take_lock("R4", 2);
    for (int k = 0; k < 5; k++) cycle();
    release_lock(2);
    clear(); cycle();

    // R3 boundary: 56 + 8 == 64 fits
    set_ag(3, 1, 1, 1, 32'h0000_5038, 7'd8);
    set_ag(1, 1, 0, 0, 32'h0000_5000, 7'd4);
    take_lock("R3", 1);
    for (int k = 0; k < 4; k++) cycle();
    release_lock(3);
    clear(); cycle();

    // R4 uncached data
    set_ag(0, 1, 1, 0, 32'h0000_6000, 7'd4);
    set_ag(1, 1, 0, 0, 32'h0000_7000, 7'd4);
    take_lock("R4", 2);
    for (int k = 0; k < 3; k++) cycle();
    release_lock(0);
    clear(); cycle();

    // R5 capability off
    en = 1'b0;
    set_ag(1, 1, 1, 1, 32'h0000_8000, 7'd4);
    set_ag(2, 1, 0, 0, 32'h0000_C000, 7'd4);
    take_lock("R5", 2);
    for (int k = 0; k < 3; k++) cycle();
    release_lock(1);
    en = 1'b1;
    clear(); cycle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule